// File: doc/BRIEF.md
# Mode-Dependent General-Purpose I/O Port

An 8-bit I/O port for a microcontroller-style register bus. Each pin works either as an ordinary I/O bit or as an external address-bus output. The choice depends on a 3-bit operating-mode input and on the pin's direction bit. Software reaches five registers through a simple read/write strobe interface: direction, output data, pin readback, pull-up select and open-drain select. The address bus the pins can carry is modelled as an 8-bit input.

The port separates two groups of reset and standby events. A power-on reset or hardware standby wipes every register, including direction. A manual reset leaves the direction register alone. Software standby freezes all registers, and a separate standby output-enable input decides whether address pins keep their last value or float. Per pin, the block drives an output value, an output enable and a pull-up enable toward the pads.

Top module: `gpio_mode_port`

## Requirements
- R1: Registers sit at fixed 16-bit offsets: direction 0xFE3B, data 0xFF0B, pin readback 0xFFBB, pull-up select 0xFE42, open-drain select 0xFE49. A write (`bus_wr` high with a matching `bus_addr`) takes effect at the next rising clock edge. Reads are combinational while `bus_rd` is high. An unmapped address, or `bus_rd` low, reads 0x00.
- R2: A read of the direction offset never shows its contents and always returns 0xFF.
- R3: `rst_n` low at a clock edge, or `hw_stby` high at a clock edge, clears all five stored registers to 0x00. While `hw_stby` is high, every `pin_oe` and `pin_pu` bit is 0.
- R4: A manual reset (`mrst_n` low at an edge) clears data, pull-up and open-drain registers but keeps direction. During a manual reset or a standby, bus writes are ignored, so direction and the other registers keep their values through software standby.
- R5: In modes 4 and 5, every pin is an address output (`pin_oe`=1, `pin_out`=`addr_in`), whatever the direction bits hold.
- R6: In mode 6, a pin whose direction bit is 1 drives `addr_in`. A pin whose direction bit is 0 is an input.
- R7: In mode 7, a pin whose direction bit is 1 drives its data-register bit. A pin whose direction bit is 0 is an input.
- R8: In modes 0 to 3, every pin is an input (`pin_oe`=0).
- R9: During software standby, address-output pins drive the `addr_in` value captured at the last edge before standby when `stby_oe` is 1, and are released (`pin_oe`=0) when `stby_oe` is 0.
- R10: Pin readback gives `pin_in` for input pins and the data-register bit for pins configured as outputs.
- R11: `pin_pu` is 1 only where the pull-up bit is 1 and the pin is an input. In modes 4 and 5 all pull-ups are therefore off.
- R12: For a mode-7 output pin with its open-drain bit at 1, a data bit of 0 drives low (`pin_oe`=1, `pin_out`=0) and a data bit of 1 releases the pin (`pin_oe`=0).
- R13: A `pin_out` bit is 0 wherever its `pin_oe` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby state |
| stby_oe | input | 1 | Address pins keep driving during software standby when 1 |
| mode | input | 3 | Operating mode |
| bus_addr | input | 16 | Register bus address (low 16 bits) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| addr_in | input | 8 | Address-bus value offered to the pins |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
Pin outputs, pull-ups and read data follow mode, standby, `addr_in` and `pin_in` in the same cycle, with no register in the path. A register write, a reset and the standby address capture show up one clock edge after the input is sampled. The bench changes inputs just after a falling edge and queues the expected values. The monitor compares them a quarter period later, so any write launched in the previous cycle has already passed its rising edge and combinational paths have settled. Standby hold is checked by changing `addr_in` in the same step that standby begins, which shows whether the value from before the edge was kept.

// File: rtl/gpio_port_pkg.sv
// Shared constants and types for the mode-dependent I/O port.
// Assumes a 16-bit register offset and a 3-bit operating mode.
package gpio_port_pkg;
    localparam int MODE_W = 3;
    localparam int OFS_W  = 16;

    localparam logic [OFS_W-1:0] OFS_DIR  = 16'hFE3B;
    localparam logic [OFS_W-1:0] OFS_DAT  = 16'hFF0B;
    localparam logic [OFS_W-1:0] OFS_PIN  = 16'hFFBB;
    localparam logic [OFS_W-1:0] OFS_PUL  = 16'hFE42;
    localparam logic [OFS_W-1:0] OFS_ODC  = 16'hFE49;

    localparam logic [MODE_W-1:0] MODE_EXT_A = 3'd4;
    localparam logic [MODE_W-1:0] MODE_EXT_B = 3'd5;
    localparam logic [MODE_W-1:0] MODE_MIXED = 3'd6;
    localparam logic [MODE_W-1:0] MODE_CHIP  = 3'd7;

    // Function a single pin takes in the current mode
    typedef enum logic [1:0] {
        PF_INPUT = 2'd0,
        PF_PORT  = 2'd1,
        PF_ADDR  = 2'd2
    } pin_func_e;
endpackage

// File: rtl/gpio_port_regs.sv
// Register file and bus decode of the I/O port.
// Holds direction, data, pull-up and open-drain registers. Writes land on
// the clock edge after the strobe. Reads are combinational. Assumes the
// readback vector is computed outside this module.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrst_n,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [W-1:0]     bus_wdata,
    input  logic [W-1:0]     pin_rb,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     dat_q,
    output logic [W-1:0]     pul_q,
    output logic [W-1:0]     odc_q,
    output logic [W-1:0]     bus_rdata
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic wr_ok;

    // Writes allowed only outside every reset and standby state
    always_comb wr_ok = bus_wr && mrst_n && !hw_stby && !sw_stby;

    // Register update with power-on/hardware-standby and manual-reset scopes
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby) begin
            dir_q <= '0;
            dat_q <= '0;
            pul_q <= '0;
            odc_q <= '0;
        end else if (!mrst_n) begin
            dat_q <= '0;
            pul_q <= '0;
            odc_q <= '0;
        end else if (wr_ok) begin
            case (bus_addr)
                OFS_DIR: dir_q <= bus_wdata;
                OFS_DAT: dat_q <= bus_wdata;
                OFS_PUL: pul_q <= bus_wdata;
                OFS_ODC: odc_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Combinational read mux; the direction register is not readable
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_DIR: bus_rdata = ALL_ONES;
                OFS_DAT: bus_rdata = dat_q;
                OFS_PIN: bus_rdata = pin_rb;
                OFS_PUL: bus_rdata = pul_q;
                OFS_ODC: bus_rdata = odc_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    assert_dir_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (dir_q == '0));

    assert_dir_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_stby && (!mrst_n || sw_stby)) |=> $stable(dir_q));

    assert_mrst_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mrst_n |=> (dat_q == '0 && pul_q == '0 && odc_q == '0));

    assert_dir_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_DIR) |-> (bus_rdata == ALL_ONES));
endmodule

// File: rtl/gpio_pin_ctrl.sv
// Per-pin function selection and pad drive of the I/O port.
// Decodes each pin's role from the mode and its direction bit, then forms
// output value, output enable, pull-up and readback. Keeps a copy of the
// address taken at the last edge outside software standby.
module gpio_pin_ctrl
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              stby_oe,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      dat_q,
    input  logic [W-1:0]      pul_q,
    input  logic [W-1:0]      odc_q,
    input  logic [W-1:0]      addr_in,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_pu,
    output logic [W-1:0]      pin_rb
);
    logic [W-1:0] addr_hold;
    logic         ext_mode;
    logic         mixed_mode;
    logic         chip_mode;

    // Capture the address each cycle until software standby begins
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_hold <= '0;
        else if (!sw_stby)
            addr_hold <= addr_in;
    end

    // Mode class decode shared by all pins
    always_comb begin
        ext_mode   = (mode == MODE_EXT_A) || (mode == MODE_EXT_B);
        mixed_mode = (mode == MODE_MIXED);
        chip_mode  = (mode == MODE_CHIP);
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_func_e fn;

        // Role of this pin in the current mode
        always_comb begin
            if (ext_mode)
                fn = PF_ADDR;
            else if (mixed_mode)
                fn = dir_q[i] ? PF_ADDR : PF_INPUT;
            else if (chip_mode)
                fn = dir_q[i] ? PF_PORT : PF_INPUT;
            else
                fn = PF_INPUT;
        end

        // Drive value and enable for this pin
        always_comb begin
            pin_out[i] = 1'b0;
            pin_oe[i]  = 1'b0;
            if (!hw_stby) begin
                case (fn)
                    PF_ADDR: begin
                        if (!sw_stby) begin
                            pin_oe[i]  = 1'b1;
                            pin_out[i] = addr_in[i];
                        end else if (stby_oe) begin
                            pin_oe[i]  = 1'b1;
                            pin_out[i] = addr_hold[i];
                        end
                    end
                    PF_PORT: begin
                        if (odc_q[i]) begin
                            pin_oe[i] = !dat_q[i];
                        end else begin
                            pin_oe[i]  = 1'b1;
                            pin_out[i] = dat_q[i];
                        end
                    end
                    default: ;
                endcase
            end
        end

        // Pull-up only for inputs; readback picks pad or data bit
        always_comb begin
            pin_pu[i] = pul_q[i] && (fn == PF_INPUT) && !hw_stby;
            pin_rb[i] = (fn == PF_INPUT) ? pin_in[i] : dat_q[i];
        end
    end

    assert_ext_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && !hw_stby && !sw_stby) |-> (pin_oe == '1 && pin_out == addr_in));

    assert_mixed_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mixed_mode && !hw_stby && !sw_stby) |-> (pin_oe == dir_q));

    assert_low_modes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode < MODE_EXT_A) |-> (pin_oe == '0));

    assert_hw_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> (pin_oe == '0 && pin_pu == '0));

    assert_pu_vs_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    assert_out_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: rtl/gpio_mode_port.sv
// Top of the mode-dependent 8-bit I/O port.
// Joins the register file and the per-pin controller. Assumes all resets
// and standby inputs are synchronous to clk.
module gpio_mode_port
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              stby_oe,
    input  logic [MODE_W-1:0] mode,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      addr_in,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_pu
);
    logic [W-1:0] dir_q;
    logic [W-1:0] dat_q;
    logic [W-1:0] pul_q;
    logic [W-1:0] odc_q;
    logic [W-1:0] pin_rb;

    gpio_port_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrst_n    (mrst_n),
        .hw_stby   (hw_stby),
        .sw_stby   (sw_stby),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .pin_rb    (pin_rb),
        .dir_q     (dir_q),
        .dat_q     (dat_q),
        .pul_q     (pul_q),
        .odc_q     (odc_q),
        .bus_rdata (bus_rdata)
    );

    gpio_pin_ctrl #(.W(W)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .stby_oe (stby_oe),
        .dir_q   (dir_q),
        .dat_q   (dat_q),
        .pul_q   (pul_q),
        .odc_q   (odc_q),
        .addr_in (addr_in),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_pu  (pin_pu),
        .pin_rb  (pin_rb)
    );
endmodule

// File: tb/gpio_mode_port_tb.sv
// Scoreboard bench: the driver queues expected values, the monitor compares
// them a quarter period after each falling edge.
module gpio_mode_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    localparam int SEL_RD  = 0;
    localparam int SEL_OUT = 1;
    localparam int SEL_OE  = 2;
    localparam int SEL_PU  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mrst_n = 1'b1;
    logic        hw_stby = 1'b0;
    logic        sw_stby = 1'b0;
    logic        stby_oe = 1'b0;
    logic [2:0]  mode = 3'd7;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  addr_in = '0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [7:0]  pin_pu;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mode_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrst_n    (mrst_n),
        .hw_stby   (hw_stby),
        .sw_stby   (sw_stby),
        .stby_oe   (stby_oe),
        .mode      (mode),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .addr_in   (addr_in),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu    (pin_pu)
    );

    task automatic tick();
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic expect_on(input int sel, input logic [7:0] exp, input string tag);
        exp_item_t it;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        tick();
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
    endtask

    task automatic reg_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        tick();
        bus_addr = a;
        bus_rd   = 1'b1;
        expect_on(SEL_RD, exp, tag);
    endtask

    // Monitor: compare queued expectations while inputs are stable
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    SEL_RD:  act = bus_rdata;
                    SEL_OUT: act = pin_out;
                    SEL_OE:  act = pin_oe;
                    default: act = pin_pu;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // Reset state, mode 7 with empty registers: all inputs
        expect_on(SEL_OE, 8'h00, "R3 reset oe");
        expect_on(SEL_PU, 8'h00, "R3 reset pu");
        reg_read(16'hFF0B, 8'h00, "R3 reset data");
        reg_read(16'hFE42, 8'h00, "R3 reset pullup");
        reg_read(16'hFE49, 8'h00, "R3 reset odc");

        // Register access
        reg_write(16'hFE3B, 8'hA5);
        reg_write(16'hFF0B, 8'h3C);
        reg_read(16'hFE3B, 8'hFF, "R2 direction unreadable");
        reg_read(16'hFF0B, 8'h3C, "R1 data readback");
        reg_read(16'h1234, 8'h00, "R1 unmapped read");
        tick();
        bus_addr = 16'hFF0B;
        expect_on(SEL_RD, 8'h00, "R1 no strobe read");

        // Mode 7 port drive and readback
        tick();
        expect_on(SEL_OE, 8'hA5, "R7 port oe");
        expect_on(SEL_OUT, 8'h24, "R7 port out");
        pin_in = 8'hF0;
        reg_read(16'hFFBB, 8'h74, "R10 pin readback");

        // Pull-ups
        reg_write(16'hFE42, 8'hFF);
        expect_on(SEL_PU, 8'h5A, "R11 pullups on inputs");

        // Open-drain
        reg_write(16'hFE49, 8'h0F);
        expect_on(SEL_OE, 8'hA1, "R12 open-drain oe");
        expect_on(SEL_OUT, 8'h20, "R13 released pins quiet");
        reg_write(16'hFE49, 8'h00);

        // Modes 4 and 5
        tick();
        mode = 3'd4;
        addr_in = 8'h96;
        expect_on(SEL_OE, 8'hFF, "R5 mode4 oe");
        expect_on(SEL_OUT, 8'h96, "R5 mode4 out");
        expect_on(SEL_PU, 8'h00, "R11 mode4 pullups off");
        tick();
        mode = 3'd5;
        addr_in = 8'h69;
        expect_on(SEL_OUT, 8'h69, "R5 mode5 out");

        // Mode 6
        tick();
        mode = 3'd6;
        addr_in = 8'h96;
        expect_on(SEL_OE, 8'hA5, "R6 mode6 oe");
        expect_on(SEL_OUT, 8'h84, "R6 mode6 out");
        expect_on(SEL_PU, 8'h5A, "R11 mode6 pullups");

        // Modes below 4
        tick();
        mode = 3'd2;
        expect_on(SEL_OE, 8'h00, "R8 mode2 inputs");

        // Software standby with address hold
        tick();
        mode = 3'd4;
        addr_in = 8'h96;
        stby_oe = 1'b1;
        tick();
        sw_stby = 1'b1;
        addr_in = 8'h11;
        expect_on(SEL_OE, 8'hFF, "R9 hold oe");
        expect_on(SEL_OUT, 8'h96, "R9 hold value");
        tick();
        stby_oe = 1'b0;
        expect_on(SEL_OE, 8'h00, "R9 float oe");
        expect_on(SEL_OUT, 8'h00, "R13 float out");
        // Writes ignored in software standby
        reg_write(16'hFF0B, 8'h00);
        reg_write(16'hFE3B, 8'h00);
        tick();
        sw_stby = 1'b0;
        mode = 3'd7;
        expect_on(SEL_OE, 8'hA5, "R4 direction kept in standby");
        reg_read(16'hFF0B, 8'h3C, "R4 data kept in standby");

        // Manual reset
        tick();
        mrst_n = 1'b0;
        tick();
        tick();
        mrst_n = 1'b1;
        reg_read(16'hFF0B, 8'h00, "R4 mrst clears data");
        reg_read(16'hFE42, 8'h00, "R4 mrst clears pullup");
        tick();
        expect_on(SEL_OE, 8'hA5, "R4 mrst keeps direction");

        // Hardware standby
        tick();
        mode = 3'd4;
        hw_stby = 1'b1;
        expect_on(SEL_OE, 8'h00, "R3 hw standby floats");
        expect_on(SEL_OUT, 8'h00, "R13 hw standby out");
        tick();
        hw_stby = 1'b0;
        mode = 3'd7;
        expect_on(SEL_OE, 8'h00, "R3 hw standby cleared direction");

        tick();
        tick();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule